// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio M·N + A. A dual-modulus prescaler stage counts input cycles in groups of M or M+1. A main counter counts N prescaler groups per output period. A swallow counter holds the prescaler at M+1 for the first A groups of each period and then lets it drop back to M. The result is a one-cycle output pulse `fp` every M·N + A input cycles. `mod_ctl` shows which modulus the prescaler is using in the group now running.

The ratio values `n_val`, `a_val` and `mod_sel` are sampled only on the clock edge that closes a period, so a new setting always starts with a whole period. A setting with N below the minimum, or with A not below N, is refused. In that case the block raises `cfg_err` and keeps running on the last accepted setting. A synchronous reset restarts the counters and takes the present inputs as the first setting. If those inputs are illegal, reset uses a safe default instead.

Top module: `pulse_swallow_div`

## Requirements
- R1: The distance from one `fp` pulse to the next is exactly M·N + A input clock cycles, with N, A and M taken from the setting accepted at the start of that period.
- R2: `mod_sel` = 1 selects base modulus M = 128 (groups of 128 or 129 cycles), and `mod_sel` = 0 selects M = 256 (groups of 256 or 257 cycles).
- R3: Within a period, `mod_ctl` is 1 for the first A·(M+1) cycles and 0 for the remaining cycles. It changes only where a prescaler group ends.
- R4: When A = 0, `mod_ctl` stays 0 for the whole period, and the period is M·N cycles.
- R5: `fp` is high for exactly one input cycle per period, which is the last cycle of the period. It is low in every other cycle.
- R6: Changes to `n_val`, `a_val` or `mod_sel` in the middle of a period do not affect that period. They are sampled on the clock edge that ends the cycle in which `fp` is high.
- R7: If `n_val` < 16 when a period boundary samples it, `cfg_err` becomes 1 for the next period and the previous setting is kept.
- R8: If `a_val` ≥ `n_val` when a boundary samples it, the setting is refused in the same way as in R7. A = N−1 is accepted.
- R9: A legal setting sampled at a boundary clears `cfg_err` and takes effect for the next period.
- R10: While `rst` is high, `fp` is 0 and the period count restarts. The first `fp` comes M·N + A − 1 cycles after the first clock edge with `rst` low. If the inputs are legal during reset they are used, with `cfg_err` = 0. Otherwise the block uses N = 16, A = 0, M = 128, with `cfg_err` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| n_val | input | 11 | Main counter value N (legal 16 to 2047) |
| a_val | input | 8 | Swallow counter value A (0 to 255, below N) |
| mod_sel | input | 1 | Prescaler base modulus select: 1 → 128, 0 → 256 |
| fp | output | 1 | Divided output, one-cycle pulse per period |
| mod_ctl | output | 1 | 1 while the current prescaler group is M+1 long |
| cfg_err | output | 1 | 1 when the last sampled setting was refused |

## Verification
If the prescaler counter is off by one, the next `fp` arrives a multiple of N cycles early or late. If the swallow counter is wrong, `mod_ctl` stays high or drops too early, and this is visible within the first A·(M+1) cycles of the period. If the setting is latched in the middle of a period or a bad setting is accepted, the period length is wrong by the next pulse, or `cfg_err` is wrong in the first cycle after the boundary. A reference model in the bench, cycle by cycle, therefore catches each of these faults within one output period.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Encoding of the modulus-select input: high picks the small base modulus.
  localparam logic SEL_SMALL = 1'b1;

  // A setting is usable when the main count reaches the minimum and the
  // swallow count stays strictly below it.
  function automatic logic cfg_ok(input int unsigned n, input int unsigned a,
                                  input int unsigned n_min);
    return (n >= n_min) && (a < n);
  endfunction

  // Base modulus of the prescaler for the chosen range.
  function automatic int unsigned base_mod(input logic big, input int unsigned m_small);
    return big ? (m_small * 2) : m_small;
  endfunction

  // Length in input cycles of one prescaler group.
  function automatic int unsigned group_len(input logic big, input logic swallow,
                                            input int unsigned m_small);
    return base_mod(big, m_small) + (swallow ? 1 : 0);
  endfunction

endpackage

// File: rtl/psd_cfg.sv
module psd_cfg #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 8,
  parameter int unsigned N_MIN = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  input  logic           sel_in,
  output logic [N_W-1:0] act_n,
  output logic [A_W-1:0] act_a,
  output logic           act_big,
  output logic           cfg_err
);

  logic ok;
  assign ok = psd_pkg::cfg_ok(32'(n_in), 32'(a_in), N_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err <= !ok;
      if (ok) begin
        act_n   <= n_in;
        act_a   <= a_in;
        act_big <= (sel_in != psd_pkg::SEL_SMALL);
      end else begin
        act_n   <= N_W'(N_MIN);
        act_a   <= '0;
        act_big <= 1'b0;
      end
    end else if (load) begin
      cfg_err <= !ok;
      if (ok) begin
        act_n   <= n_in;
        act_a   <= a_in;
        act_big <= (sel_in != psd_pkg::SEL_SMALL);
      end
    end
  end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned M_LOG2 = 7,
  localparam int unsigned M_SMALL = 1 << M_LOG2,
  localparam int unsigned PC_W    = M_LOG2 + 2
) (
  input  logic clk,
  input  logic rst,
  input  logic big,
  input  logic swallow,
  output logic tick
);

  logic [PC_W-1:0] cnt;
  logic [PC_W-1:0] last;

  assign last = PC_W'(psd_pkg::group_len(big, swallow, M_SMALL) - 1);
  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + PC_W'(1);
  end

endmodule

// File: rtl/psd_counters.sv
module psd_counters #(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N_W-1:0] act_n,
  input  logic [A_W-1:0] act_a,
  output logic           mod_ctl,
  output logic           period_end
);

  logic [N_W-1:0] n_cnt;
  logic [A_W-1:0] s_cnt;
  logic           n_last;

  assign n_last     = (n_cnt == act_n - N_W'(1));
  assign period_end = tick && n_last;
  assign mod_ctl    = (s_cnt < act_a);

  always_ff @(posedge clk) begin
    if (rst || period_end) begin
      n_cnt <= '0;
      s_cnt <= '0;
    end else if (tick) begin
      n_cnt <= n_cnt + N_W'(1);
      if (mod_ctl) s_cnt <= s_cnt + A_W'(1);
    end
  end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int unsigned N_W    = 11,
  parameter int unsigned A_W    = 8,
  parameter int unsigned N_MIN  = 16,
  parameter int unsigned M_LOG2 = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  input  logic           mod_sel,
  output logic           fp,
  output logic           mod_ctl,
  output logic           cfg_err
);

  // Named internal events, visible to the bound checker.
  logic           pre_tick;
  logic           period_end;
  logic [N_W-1:0] act_n;
  logic [A_W-1:0] act_a;
  logic           act_big;

  psd_cfg #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (period_end),
    .n_in    (n_val),
    .a_in    (a_val),
    .sel_in  (mod_sel),
    .act_n   (act_n),
    .act_a   (act_a),
    .act_big (act_big),
    .cfg_err (cfg_err)
  );

  psd_prescaler #(.M_LOG2(M_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .big     (act_big),
    .swallow (mod_ctl),
    .tick    (pre_tick)
  );

  psd_counters #(.N_W(N_W), .A_W(A_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (pre_tick),
    .act_n      (act_n),
    .act_a      (act_a),
    .mod_ctl    (mod_ctl),
    .period_end (period_end)
  );

  assign fp = period_end;

endmodule

// File: rtl/psd_check.sv
module psd_check #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 8,
  parameter int unsigned N_MIN = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           fp,
  input logic           mod_ctl,
  input logic           cfg_err,
  input logic           pre_tick,
  input logic [N_W-1:0] act_n,
  input logic [A_W-1:0] act_a,
  input logic           act_big
);

  a_r5_fp_single: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

  a_r1_fp_on_group_end: assert property (@(posedge clk) disable iff (rst)
    fp |-> (pre_tick && !mod_ctl));

  a_r3_modctl_at_group_edge: assert property (@(posedge clk) disable iff (rst)
    !pre_tick |=> $stable(mod_ctl));

  a_r4_no_swallow_when_zero: assert property (@(posedge clk) disable iff (rst)
    (act_a == '0) |-> !mod_ctl);

  a_r6_cfg_held_in_period: assert property (@(posedge clk) disable iff (rst)
    !fp |=> ($stable(act_n) && $stable(act_a) && $stable(act_big)));

  a_r7_err_moves_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !fp |=> $stable(cfg_err));

  a_r8_active_cfg_legal: assert property (@(posedge clk) disable iff (rst)
    (32'(act_n) >= N_MIN) && (act_a < A_W'(act_n) || 32'(act_n) > ((1 << A_W) - 1)));

endmodule

bind pulse_swallow_div psd_check #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_check (
  .clk      (clk),
  .rst      (rst),
  .fp       (fp),
  .mod_ctl  (mod_ctl),
  .cfg_err  (cfg_err),
  .pre_tick (pre_tick),
  .act_n    (act_n),
  .act_a    (act_a),
  .act_big  (act_big)
);

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] n_val = 11'd16;
  logic [7:0]  a_val = 8'd3;
  logic        mod_sel = 1'b1;
  logic        fp, mod_ctl, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_swallow_div uut (
    .clk(clk), .rst(rst), .n_val(n_val), .a_val(a_val), .mod_sel(mod_sel),
    .fp(fp), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: one integer cycle index per period.
  int m_cyc = 0, m_n = 16, m_a = 0, m_m = 128, m_err = 0;
  bit m_valid = 0;

  function automatic bit in_legal();
    return (int'(n_val) >= 16) && (int'(a_val) < int'(n_val));
  endfunction

  task automatic take_inputs();
    m_n = int'(n_val);
    m_a = int'(a_val);
    m_m = mod_sel ? 128 : 256;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 1;
      m_cyc = 0;
      if (in_legal()) begin take_inputs(); m_err = 0; end
      else begin m_n = 16; m_a = 0; m_m = 128; m_err = 1; end
    end else if (m_valid) begin
      if (m_cyc == m_m * m_n + m_a - 1) begin
        m_cyc = 0;
        if (in_legal()) begin take_inputs(); m_err = 0; end
        else m_err = 1;
      end else begin
        m_cyc++;
      end
    end
  end

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(fp == (m_cyc == m_m * m_n + m_a - 1), "R1 fp per-cycle", int'(fp),
          int'(m_cyc == m_m * m_n + m_a - 1));
      chk(mod_ctl == (m_cyc < m_a * (m_m + 1)), "R3 mod_ctl per-cycle", int'(mod_ctl),
          int'(m_cyc < m_a * (m_m + 1)));
      chk(cfg_err == m_err[0], "R7 cfg_err per-cycle", int'(cfg_err), m_err);
    end
  end

  task automatic to_fp(output int len);
    len = 0;
    while (!fp) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic measure(output int len, output int hi);
    len = 0;
    hi = 0;
    do begin
      @(negedge clk);
      len++;
      if (mod_ctl) hi++;
    end while (!fp);
  endtask

  task automatic set_cfg(input int n, input int a, input bit sel);
    n_val = 11'(n);
    a_val = 8'(a);
    mod_sel = sel;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int len, hi;
    repeat (3) @(negedge clk);
    // R10 reset state with legal inputs (N=16, A=3, M=128)
    chk(fp == 1'b0, "R10 reset fp", int'(fp), 0);
    chk(cfg_err == 1'b0, "R10 reset cfg_err", int'(cfg_err), 0);
    chk(mod_ctl == 1'b1, "R10 reset mod_ctl", int'(mod_ctl), 1);
    rst = 1'b0;
    to_fp(len);
    chk(len == 2050, "R10 first fp after reset", len, 2050);
    measure(len, hi);
    chk(len == 2051, "R1 period M=128 N=16 A=3", len, 2051);
    chk(hi == 387, "R3 swallow cycles A*(M+1)", hi, 387);

    // R2: large modulus
    set_cfg(17, 5, 1'b0);
    measure(len, hi);
    chk(len == 4357, "R2 period M=256 N=17 A=5", len, 4357);
    chk(hi == 1285, "R2 swallow cycles with M=256", hi, 1285);

    // R4: A = 0
    set_cfg(16, 0, 1'b1);
    measure(len, hi);
    chk(len == 2048, "R4 period with A=0", len, 2048);
    chk(hi == 0, "R4 mod_ctl never high", hi, 0);

    // R8 boundary: A = N-1 accepted
    set_cfg(16, 15, 1'b1);
    measure(len, hi);
    chk(len == 2063, "R8 period with A=N-1", len, 2063);
    chk(hi == 1935, "R8 swallow cycles with A=N-1", hi, 1935);
    chk(cfg_err == 1'b0, "R8 A=N-1 not refused", int'(cfg_err), 0);

    // R6: mid-period change waits for the boundary
    set_cfg(16, 2, 1'b1);
    measure(len, hi);
    chk(len == 2050, "R6 setup period", len, 2050);
    repeat (10) @(negedge clk);
    set_cfg(20, 0, 1'b0);
    to_fp(len);
    chk(len == 2040, "R6 current period unchanged", len, 2040);
    chk(cfg_err == 1'b0, "R6 no error mid-period", int'(cfg_err), 0);
    measure(len, hi);
    chk(len == 5120, "R6 new setting after boundary", len, 5120);

    // R7: N below minimum refused, old setting kept
    set_cfg(8, 0, 1'b1);
    measure(len, hi);
    chk(len == 5120, "R7 old period kept", len, 5120);
    chk(cfg_err == 1'b1, "R7 cfg_err raised", int'(cfg_err), 1);

    // R8: A equal to N refused
    set_cfg(20, 20, 1'b1);
    measure(len, hi);
    chk(len == 5120, "R8 old period kept", len, 5120);
    chk(cfg_err == 1'b1, "R8 cfg_err raised", int'(cfg_err), 1);

    // R9: legal setting clears the error
    set_cfg(16, 1, 1'b1);
    measure(len, hi);
    chk(len == 2049, "R9 new period", len, 2049);
    chk(cfg_err == 1'b0, "R9 cfg_err cleared", int'(cfg_err), 0);

    // R10: reset with illegal inputs falls back to the default
    rst = 1'b1;
    set_cfg(4, 0, 1'b0);
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b1, "R10 illegal reset cfg_err", int'(cfg_err), 1);
    chk(fp == 1'b0, "R10 illegal reset fp", int'(fp), 0);
    chk(mod_ctl == 1'b0, "R10 default mod_ctl", int'(mod_ctl), 0);
    rst = 1'b0;
    to_fp(len);
    chk(len == 2047, "R10 default period after reset", len, 2047);
    set_cfg(16, 7, 1'b0);
    measure(len, hi);
    chk(len == 4103, "R9 recovery M=256 N=16 A=7", len, 4103);
    chk(hi == 1799, "R3 swallow cycles after recovery", hi, 1799);
    chk(cfg_err == 1'b0, "R9 cfg_err cleared after reset", int'(cfg_err), 0);

    @(negedge clk);
    finish_run();
  end

endmodule